// File: doc/BRIEF.md
# Group-Rotating DMA Bus Arbiter

This block decides which requester may drive a shared internal I/O data bus in the next cycle. Requesters are DMA-capable peripheral channels, plus two extra inputs that by convention carry core accesses to the I/O registers and transfer-control-block chain loads. These two compete under the same rules as the channels. A new decision is taken on every clock edge. The winner is held in a register and presented as a one-hot grant together with its index.

A mode bit selects one of two schemes. Fixed mode always favours the lowest requester index. Rotating mode sorts requesters into six groups, named A to F, using a parameter table. The groups take turns in a circular order. Inside a group, the lowest index wins. When the granted requester reports that its transfer is complete, its group drops to last place and the group after it moves to first. After reset the order is A first and F last, which agrees with fixed mode under the default table.

Top module: `dma_group_arb`

## Requirements
- R1: The grant outputs are registered. The values present after a clock edge are the decision taken from `req_i`, `cfg_i` and `done_i` as sampled at that edge, and a fresh decision is made on every edge.
- R2: Bit 7 of `cfg_i` selects the mode: 0 is fixed priority and 1 is group-rotating priority. The other seven bits of `cfg_i` have no effect on the grant.
- R3: In fixed mode, the requesting input with the lowest index is granted.
- R4: In rotating mode, the first group in the current circular order that has any request wins. Inside that group, the lowest requesting index is granted. Default group table, by index 0..9: A, A, B, C, C, D, E, E, F, F (A=0 … F=5).
- R5: In rotating mode, if `done_i` is high while a grant is valid, the group of the granted requester moves to last place and the following group (F wraps to A) moves to first. The decision taken at that same edge already uses the new order.
- R6: `done_i` leaves the group order unchanged when no grant is valid or when the mode is fixed.
- R7: At most one grant bit is set. If no input requests, no grant is issued, and the group order is not changed by that cycle.
- R8: Reset (`rst_ni` low, asynchronous) clears the grant and restores the order A, B, C, D, E, F with A first.
- R9: A change of the mode bit takes effect at the next decision edge, and the rotation state is kept across mode changes.
- R10: `gnt_vld_o` is high exactly when `gnt_o` is non-zero, and `gnt_idx_o` then gives the index of the set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 8 | Configuration byte; bit 7 selects the mode |
| req_i | input | N_REQ (10) | Request per requester; the two highest indices carry core register access and chain load |
| done_i | input | 1 | Pulse: the currently granted transfer has completed |
| gnt_o | output | N_REQ (10) | One-hot grant |
| gnt_vld_o | output | 1 | A grant is active |
| gnt_idx_o | output | IDX_W (4) | Index of the granted requester |

## Verification
The hardest state to reach from the ports is a rotation pointer that has moved away from group A, and then wrapping from group F back to A. Reaching it needs a grant in rotating mode with a completion pulse on that grant, and a request pattern that spans several groups, so that the new order becomes visible. Directed sequences move the order to group D, then pulse completion in fixed mode to show that the order stays put, then walk a group F grant through completion to force the wrap. Seeded random traffic with sparse completion pulses and occasional mode flips then covers the other pointer positions against a bench model.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned GRP_W = 3;
  // Default map, entry i at bits [3i+2:3i]: A A B C C D E E F F
  localparam logic [29:0] DEF_GRP_MAP =
    {3'd5, 3'd5, 3'd4, 3'd4, 3'd3, 3'd2, 3'd2, 3'd1, 3'd0, 3'd0};
endpackage

// File: rtl/arb_grp_reqs.sv
module arb_grp_reqs
  import dma_arb_pkg::*;
#(
  parameter int unsigned N_REQ = 10,
  parameter int unsigned N_GRP = 6,
  parameter logic [N_REQ*GRP_W-1:0] GRP_MAP = DEF_GRP_MAP
) (
  input  logic [N_REQ-1:0] req_i,
  output logic [N_GRP-1:0] grp_req_o
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int i = 0; i < N_REQ; i++)
        if (GRP_MAP[i*GRP_W +: GRP_W] == GRP_W'(g)) hit = hit | req_i[i];
    end
    assign grp_req_o[g] = hit;
  end
endmodule

// File: rtl/arb_rot_state.sv
module arb_rot_state
  import dma_arb_pkg::*;
#(
  parameter int unsigned N_GRP = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [GRP_W-1:0] done_grp_i,
  output logic [GRP_W-1:0] ptr_q_o,
  output logic [GRP_W-1:0] ptr_d_o
);
  logic [GRP_W-1:0] ptr_q;

  always_comb begin
    ptr_d_o = ptr_q;
    if (adv_i)
      ptr_d_o = (done_grp_i == GRP_W'(N_GRP - 1)) ? '0 : done_grp_i + GRP_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d_o;

  assign ptr_q_o = ptr_q;
endmodule

// File: rtl/arb_grp_pick.sv
module arb_grp_pick
  import dma_arb_pkg::*;
#(
  parameter int unsigned N_GRP = 6
) (
  input  logic [N_GRP-1:0] grp_req_i,
  input  logic [GRP_W-1:0] ptr_i,
  output logic [GRP_W-1:0] win_grp_o,
  output logic             any_o
);
  always_comb begin
    win_grp_o = '0;
    any_o     = 1'b0;
    for (int k = 0; k < N_GRP; k++) begin
      int s;
      s = int'(ptr_i) + k;
      if (s >= int'(N_GRP)) s = s - int'(N_GRP);
      if (!any_o && grp_req_i[s]) begin
        any_o     = 1'b1;
        win_grp_o = GRP_W'(s);
      end
    end
  end
endmodule

// File: rtl/dma_group_arb.sv
module dma_group_arb
  import dma_arb_pkg::*;
#(
  parameter int unsigned N_REQ    = 10,
  parameter int unsigned N_GRP    = 6,
  parameter int unsigned MODE_BIT = 7,
  parameter logic [N_REQ*GRP_W-1:0] GRP_MAP = DEF_GRP_MAP,
  localparam int unsigned IDX_W = $clog2(N_REQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       cfg_i,
  input  logic [N_REQ-1:0] req_i,
  input  logic             done_i,
  output logic [N_REQ-1:0] gnt_o,
  output logic             gnt_vld_o,
  output logic [IDX_W-1:0] gnt_idx_o
);
  logic             rot_mode;
  logic [N_REQ-1:0] gnt_q, gnt_d, cand;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             vld_q, vld_d;
  logic [GRP_W-1:0] cur_grp, ptr_q, ptr_d, win_grp;
  logic [N_GRP-1:0] grp_req;
  logic             grp_any, adv;
  logic [N_REQ-1:0] in_win;

  assign rot_mode = cfg_i[MODE_BIT];

  // group of the grant currently held
  always_comb begin
    cur_grp = '0;
    for (int i = 0; i < N_REQ; i++)
      if (gnt_q[i]) cur_grp = GRP_MAP[i*GRP_W +: GRP_W];
  end

  assign adv = rot_mode & done_i & vld_q;

  arb_rot_state #(.N_GRP(N_GRP)) u_rot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .done_grp_i (cur_grp),
    .ptr_q_o    (ptr_q),
    .ptr_d_o    (ptr_d)
  );

  arb_grp_reqs #(.N_REQ(N_REQ), .N_GRP(N_GRP), .GRP_MAP(GRP_MAP)) u_grq (
    .req_i     (req_i),
    .grp_req_o (grp_req)
  );

  arb_grp_pick #(.N_GRP(N_GRP)) u_gpk (
    .grp_req_i (grp_req),
    .ptr_i     (ptr_d),
    .win_grp_o (win_grp),
    .any_o     (grp_any)
  );

  for (genvar i = 0; i < N_REQ; i++) begin : g_mem
    assign in_win[i] = (GRP_MAP[i*GRP_W +: GRP_W] == win_grp) & grp_any;
  end

  assign cand = rot_mode ? (req_i & in_win) : req_i;

  // lowest index among candidates
  always_comb begin
    gnt_d = '0;
    idx_d = '0;
    vld_d = 1'b0;
    for (int i = N_REQ - 1; i >= 0; i--)
      if (cand[i]) begin
        gnt_d = '0;
        gnt_d[i] = 1'b1;
        idx_d = IDX_W'(i);
        vld_d = 1'b1;
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      gnt_q <= '0;
      idx_q <= '0;
      vld_q <= 1'b0;
    end else begin
      gnt_q <= gnt_d;
      idx_q <= idx_d;
      vld_q <= vld_d;
    end

  assign gnt_o     = gnt_q;
  assign gnt_vld_o = vld_q;
  assign gnt_idx_o = idx_q;
endmodule

// File: rtl/dma_group_arb_chk.sv
module dma_group_arb_chk
  import dma_arb_pkg::*;
#(
  parameter int unsigned N_REQ    = 10,
  parameter int unsigned N_GRP    = 6,
  parameter int unsigned MODE_BIT = 7,
  parameter logic [N_REQ*GRP_W-1:0] GRP_MAP = DEF_GRP_MAP,
  localparam int unsigned IDX_W = $clog2(N_REQ)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       cfg_i,
  input logic [N_REQ-1:0] req_i,
  input logic             done_i,
  input logic [N_REQ-1:0] gnt_o,
  input logic             gnt_vld_o,
  input logic [IDX_W-1:0] gnt_idx_o,
  input logic [GRP_W-1:0] ptr_i
);
  logic [GRP_W-1:0] nxt_grp;
  always_comb begin
    nxt_grp = '0;
    for (int i = 0; i < N_REQ; i++)
      if (gnt_idx_o == IDX_W'(i))
        nxt_grp = (GRP_MAP[i*GRP_W +: GRP_W] == GRP_W'(N_GRP - 1)) ? '0
                : GRP_MAP[i*GRP_W +: GRP_W] + GRP_W'(1);
  end

  p_gnt_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  p_gnt_has_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0) |-> ((gnt_o & ~$past(req_i)) == '0));

  p_idle_no_gnt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(req_i) == '0) |-> (gnt_o == '0));

  p_fixed_lowest_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o != '0) && !$past(cfg_i[MODE_BIT])) |->
      (((gnt_o - N_REQ'(1)) & $past(req_i)) == '0));

  p_vld_match_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_vld_o == (gnt_o != '0)) && (!gnt_vld_o || gnt_o[gnt_idx_o]));

  p_rot_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[MODE_BIT] && done_i && gnt_vld_o) |=> (ptr_i == $past(nxt_grp)));

  p_order_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_i[MODE_BIT] && done_i && gnt_vld_o) |=> $stable(ptr_i));
endmodule

bind dma_group_arb dma_group_arb_chk #(
  .N_REQ(N_REQ), .N_GRP(N_GRP), .MODE_BIT(MODE_BIT), .GRP_MAP(GRP_MAP)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_i     (cfg_i),
  .req_i     (req_i),
  .done_i    (done_i),
  .gnt_o     (gnt_o),
  .gnt_vld_o (gnt_vld_o),
  .gnt_idx_o (gnt_idx_o),
  .ptr_i     (ptr_q)
);

// File: tb/tb_dma_group_arb.sv
`timescale 1ns/1ps
module tb_dma_group_arb;
  localparam int N = 10;
  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [7:0]    cfg_i = '0;
  logic [N-1:0]  req_i = '0;
  logic          done_i = 1'b0;
  logic [N-1:0]  gnt_o;
  logic          gnt_vld_o;
  logic [3:0]    gnt_idx_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  int m_ptr = 0;
  logic [N-1:0] m_gnt = '0;

  always #4 clk = ~clk;

  dma_group_arb dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_i(cfg_i), .req_i(req_i),
    .done_i(done_i), .gnt_o(gnt_o), .gnt_vld_o(gnt_vld_o), .gnt_idx_o(gnt_idx_o)
  );

  function automatic int grp_of(int i);
    case (i)
      0, 1: return 0;
      2:    return 1;
      3, 4: return 2;
      5:    return 3;
      6, 7: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int idx_of(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic logic [N-1:0] pick(logic [N-1:0] r, bit rot, int p);
    logic [N-1:0] g = '0;
    if (!rot) begin
      for (int i = 0; i < N; i++) if (r[i]) begin g[i] = 1'b1; return g; end
    end else begin
      for (int k = 0; k < 6; k++)
        for (int i = 0; i < N; i++)
          if (r[i] && grp_of(i) == (p + k) % 6) begin g[i] = 1'b1; return g; end
    end
    return g;
  endfunction

  task automatic chk(string tag);
    logic [3:0] ei = 4'(idx_of(m_gnt));
    bit ok = (gnt_o == m_gnt) && (gnt_vld_o == (m_gnt != 0)) &&
             (m_gnt == 0 || gnt_idx_o == ei);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: gnt=%b vld=%0d idx=%0d expected gnt=%b vld=%0d idx=%0d",
               tag, gnt_o, gnt_vld_o, gnt_idx_o, m_gnt, (m_gnt != 0), ei);
    end
  endtask

  task automatic step(logic [N-1:0] r, logic [7:0] c, bit d, string tag);
    @(negedge clk);
    req_i = r; cfg_i = c; done_i = d;
    if (d && c[7] && m_gnt != 0) m_ptr = (grp_of(idx_of(m_gnt)) + 1) % 6;
    m_gnt = pick(r, c[7], m_ptr);
    @(posedge clk);
    #2;
    chk(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_2126));
    repeat (3) @(posedge clk);
    #2;
    chk("R8 reset no grant");
    @(negedge clk); rst_ni = 1'b1;

    step(10'b10_0000_0110, 8'h00, 0, "R3 fixed lowest index");
    step(10'b11_1111_1000, 8'h7F, 0, "R2 non-mode cfg bits ignored");
    step(10'b10_0000_0100, 8'h80, 0, "R4 R8 rotating start order A first");
    step(10'b00_0001_1000, 8'h80, 0, "R4 lowest inside group");
    step(10'b00_0000_0000, 8'h80, 0, "R7 no request no grant");
    step(10'b00_0000_1000, 8'h80, 1, "R6 done without grant keeps order");
    step(10'b11_1111_1111, 8'h80, 0, "R6 order still A first");
    step(10'b00_0001_1000, 8'h80, 0, "R4 grant group C");
    step(10'b11_1111_1111, 8'h80, 1, "R5 group C done, D first");
    step(10'b11_1111_1111, 8'h00, 1, "R9 fixed after switch");
    step(10'b11_1110_0000, 8'h00, 1, "R6 fixed done");
    step(10'b11_1111_1111, 8'h80, 0, "R6 R9 order still D first");
    step(10'b10_0000_0000, 8'h80, 0, "R4 grant group F");
    step(10'b11_1111_1111, 8'h80, 1, "R5 wrap F to A");
    step(10'b11_1111_1110, 8'h80, 1, "R5 group A done, B first");
    step(10'b11_1111_1111, 8'h00, 0, "R9 mode change next edge");

    for (int n = 0; n < 4000; n++) begin
      logic [N-1:0] r = N'($urandom);
      logic [7:0] c = cfg_i;
      if ($urandom_range(0, 7) == 0) r = '0;
      if ($urandom_range(0, 3) == 0) r = r & N'($urandom);
      if ($urandom_range(0, 15) == 0) c[7] = ~c[7];
      c[6:0] = 7'($urandom);
      step(r, c, ($urandom_range(0, 3) == 0), "R1 R4 R5 random");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule